// File: doc/BRIEF.md
# Gated Serial Byte Transmitter

This block sends bytes over a single asynchronous serial line. Software writes a small control register that holds a global run bit, a send-permission bit, a receive-permission bit (stored but unused in this path) and a flow-control bit. Bytes arrive through a push port into a 16-entry queue. The serializer pulls one byte at a time and sends it as a framed character. It paces every bit with a baud tick input, 16 ticks per bit.

A new character starts only when four conditions hold at once: the run bit is set, the send-permission bit is set, the queue holds data and flow control allows it. When flow control is on, the serializer looks at a synchronized copy of the clear-to-send input, and only at the moment a character would begin. Clearing the run bit, or dropping clear-to-send, never cuts off a character that is already on the line. It always finishes through its stop bit. A second register holds a queue-enable bit, and clearing it empties the queue. A status register shows busy, sticky overflow, empty and full, so software can wait for the line to go quiet before it reprograms the control register.

Top module: `uart_tx_gated`

## Requirements
- R1: After reset, the control register (address 0) reads 0x0000_0300. The queue-config register (address 1) reads 0x1. Status (address 2) reads busy=0, overflow=0, empty=1, full=0. tx_out is high.
- R2: Control bits 0 (run), 8 (send permit), 9 (receive permit) and 15 (flow control) are storable. Every other bit, including 31:16, reads zero whatever was written. Address 3 reads zero.
- R3: No character starts while control bit 0 is 0. Queued bytes stay queued.
- R4: A character is one start bit (0), then 8 data bits LSB first, then one stop bit (1). Each bit lasts 16 cycles in which baud_tick is high. The line idles at 1.
- R5: If control bit 0 is cleared during a character, that character completes through its stop bit, and no further character starts.
- R6: With control bit 15 set, a character starts only while the synchronized cts input is 1. With bit 15 clear, cts has no effect.
- R7: Dropping cts during a character does not shorten or alter that character.
- R8: Writing 0 to bit 0 of address 1 while it holds 1 discards every queued byte. A push in that same cycle is also discarded.
- R9: Status bit 0 (busy) is 1 from the first start bit until the last stop bit ends. It stays 1 without a gap across back-to-back characters.
- R10: The queue holds 16 bytes. A push into a full queue is dropped and sets status bit 1 (overflow). That bit stays set until a 1 is written to bit 1 of address 2. Status bit 3 reports full and bit 2 reports empty.
- R11: No character starts while control bit 8 is 0, even with bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| push_valid | input | 1 | Push one byte into the queue |
| push_data | input | 8 | Byte to push |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| cts | input | 1 | Clear-to-send, active high, asynchronous |
| tx_out | output | 1 | Serial line |

## Verification
Two collisions are driven on purpose. The first is a queue flush in the same cycle as a push. The bench raises the flush write and the push on one falling edge. It then expects status to report an empty queue, and it expects no character after the run bit is set. The second is a push landing while the serializer pops at the start of a character. Bytes are pushed back to back as transmission begins. The scoreboard then compares every character on the line, in order, with the queue of pushed bytes, while busy is sampled every cycle to catch any gap.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   localparam int REG_W       = 32;
   localparam int ADDR_W      = 2;
   localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] A_QCFG  = 2'd1;
   localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;
   localparam int CB_RUN      = 0;
   localparam int CB_TXOK     = 8;
   localparam int CB_RXOK     = 9;
   localparam int CB_FLOW     = 15;
   localparam logic [REG_W-1:0] CTRL_RST  = 32'h0000_0300;
   localparam logic [REG_W-1:0] CTRL_MASK = 32'h0000_8301;
   localparam int SB_BUSY = 0;
   localparam int SB_OVF  = 1;
   localparam int SB_EMPTY = 2;
   localparam int SB_FULL = 3;
   typedef enum logic [0:0] {SH_IDLE = 1'b0, SH_SEND = 1'b1} sh_state_e;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   input  logic             flush,
   output logic             empty,
   output logic             full,
   output logic             drop_evt
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("uart_tx_fifo: DEPTH must be a power of two, at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("uart_tx_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic do_push, do_pop;

   assign empty    = (count == '0);
   assign full     = (count == CNT_W'(DEPTH));
   assign do_push  = push && !full && !flush;
   assign do_pop   = pop && !empty && !flush;
   assign drop_evt = push && full && !flush;
   assign pop_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
   assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> full);
endmodule

// File: rtl/uart_tx_sync.sv
module uart_tx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("uart_tx_sync: STAGES must be at least 1");
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
   import uart_tx_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int OVS   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             can_start,
   input  logic [WIDTH-1:0] data,
   output logic             take,
   output logic             busy,
   output logic             last_done,
   output logic             tx
);
   localparam int FRAME = WIDTH + 2;
   localparam int OS_W  = (OVS > 1) ? $clog2(OVS) : 1;
   localparam int BIT_W = $clog2(FRAME);

   generate
      if (OVS < 2) begin : g_bad_ovs
         $error("uart_tx_shifter: OVS must be at least 2");
      end
      if (WIDTH < 5) begin : g_bad_width
         $error("uart_tx_shifter: WIDTH must be at least 5");
      end
   endgenerate

   sh_state_e        state;
   logic [FRAME-1:0] shreg;
   logic [OS_W-1:0]  os_cnt;
   logic [BIT_W-1:0] bit_cnt;
   logic             os_wrap;

   assign busy      = (state == SH_SEND);
   assign take      = (state == SH_IDLE) && can_start;
   assign os_wrap   = tick && (os_cnt == OS_W'(OVS - 1));
   assign last_done = busy && os_wrap && (bit_cnt == BIT_W'(FRAME - 1));
   assign tx        = shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SH_IDLE;
         shreg   <= '1;
         os_cnt  <= '0;
         bit_cnt <= '0;
      end else begin
         case (state)
            SH_IDLE: begin
               if (can_start) begin
                  state   <= SH_SEND;
                  shreg   <= {1'b1, data, 1'b0};
                  os_cnt  <= '0;
                  bit_cnt <= '0;
               end
            end
            SH_SEND: begin
               if (tick) begin
                  if (os_wrap) begin
                     os_cnt <= '0;
                     if (bit_cnt == BIT_W'(FRAME - 1)) begin
                        state <= SH_IDLE;
                        shreg <= '1;
                     end else begin
                        bit_cnt <= bit_cnt + BIT_W'(1);
                        shreg   <= {1'b1, shreg[FRAME-1:1]};
                     end
                  end else begin
                     os_cnt <= os_cnt + OS_W'(1);
                  end
               end
            end
            default: state <= SH_IDLE;
         endcase
      end
   end

   assert_frame_runs_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last_done) |=> busy);
   assert_idle_line_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx);
   assert_start_bit_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !tx);
endmodule

// File: rtl/uart_tx_gated.sv
module uart_tx_gated
   import uart_tx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int FIFO_DEPTH  = 16,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic              baud_tick,
   input  logic              cts,
   output logic              tx_out
);
   logic [REG_W-1:0]  ctrl_q;
   logic              qen_q;
   logic              ovf_q;
   logic              cts_s;
   logic              flush;
   logic              q_empty, q_full, q_drop;
   logic [DATA_W-1:0] q_data;
   logic              sh_take, sh_busy, sh_last, can_start;
   logic              run, txok, flow;

   assign run   = ctrl_q[CB_RUN];
   assign txok  = ctrl_q[CB_TXOK];
   assign flow  = ctrl_q[CB_FLOW];
   assign flush = reg_we && (reg_addr == A_QCFG) && !reg_wdata[0] && qen_q;
   assign can_start = run && txok && (!flow || cts_s) && !q_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         qen_q  <= 1'b1;
         ovf_q  <= 1'b0;
      end else begin
         if (reg_we && reg_addr == A_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
         if (reg_we && reg_addr == A_QCFG) qen_q  <= reg_wdata[0];
         if (q_drop)
            ovf_q <= 1'b1;
         else if (reg_we && reg_addr == A_STAT && reg_wdata[SB_OVF])
            ovf_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: reg_rdata = ctrl_q;
         A_QCFG: reg_rdata[0] = qen_q;
         A_STAT: begin
            reg_rdata[SB_BUSY]  = sh_busy || can_start;
            reg_rdata[SB_OVF]   = ovf_q;
            reg_rdata[SB_EMPTY] = q_empty;
            reg_rdata[SB_FULL]  = q_full;
         end
         default: reg_rdata = '0;
      endcase
   end

   uart_tx_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
      .clk(clk), .rst_n(rst_n), .d(cts), .q(cts_s)
   );

   uart_tx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push_valid), .push_data(push_data),
      .pop(sh_take), .pop_data(q_data),
      .flush(flush), .empty(q_empty), .full(q_full), .drop_evt(q_drop)
   );

   uart_tx_shifter #(.WIDTH(DATA_W), .OVS(OVS)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick),
      .can_start(can_start), .data(q_data),
      .take(sh_take), .busy(sh_busy), .last_done(sh_last), .tx(tx_out)
   );

   assert_start_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sh_busy) |-> $past(ctrl_q[CB_RUN]));
   assert_start_needs_txok_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sh_busy) |-> $past(ctrl_q[CB_TXOK]));
   assert_start_needs_cts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sh_busy) |-> $past(!ctrl_q[CB_FLOW] || cts_s));
   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !(reg_we && reg_addr == A_STAT && reg_wdata[SB_OVF])) |=> ovf_q);
   assert_drop_sets_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
      q_drop |=> ovf_q);
   assert_ctrl_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: tb/test_uart_tx_gated.sv
module test_uart_tx_gated;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        push_valid = 1'b0;
   logic [7:0]  push_data = '0;
   logic        baud_tick = 1'b1;
   logic        cts = 1'b0;
   logic        tx_out;

   int total = 0;
   int bad = 0;
   int frames = 0;
   bit done = 1'b0;
   logic [7:0] expq [$];

   always #10 clk = ~clk;

   uart_tx_gated i_uart_tx_gated (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push_valid(push_valid),
      .push_data(push_data), .baud_tick(baud_tick), .cts(cts), .tx_out(tx_out)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic push(input logic [7:0] b, input bit expect_sent);
      @(negedge clk);
      push_valid = 1'b1; push_data = b;
      if (expect_sent) expq.push_back(b);
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard monitor: decode each character on the line (R4)
   initial begin
      logic [7:0] got;
      logic [7:0] exp;
      forever begin
         @(negedge clk);
         if (rst_n && tx_out === 1'b0) begin
            repeat (8) @(negedge clk);
            check(tx_out === 1'b0, "R4 start bit", {31'd0, tx_out}, 32'd0);
            for (int i = 0; i < 8; i++) begin
               repeat (16) @(negedge clk);
               got[i] = tx_out;
            end
            repeat (16) @(negedge clk);
            check(tx_out === 1'b1, "R4/R5/R7 stop bit", {31'd0, tx_out}, 32'd1);
            if (expq.size() == 0) begin
               check(1'b0, "R4 unexpected character", {24'd0, got}, 32'd0);
            end else begin
               exp = expq.pop_front();
               check(got === exp, "R4 character data", {24'd0, got}, {24'd0, exp});
            end
            frames++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int f0;
      int gaps;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset values
      rd(2'd0, r); check(r == 32'h0000_0300, "R1 ctrl reset", r, 32'h300);
      rd(2'd1, r); check(r == 32'h1, "R1 qcfg reset", r, 32'h1);
      rd(2'd2, r); check(r == 32'h4, "R1 status reset", r, 32'h4);
      check(tx_out === 1'b1, "R1 line idle", {31'd0, tx_out}, 32'd1);

      // R2 reserved bits
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, r); check(r == 32'h0000_8301, "R2 implemented bits", r, 32'h8301);
      rd(2'd3, r); check(r == 32'h0, "R2 unused address", r, 32'h0);
      wr(2'd0, 32'h0000_0300);

      // R3 no start while run bit clear
      push(8'hA5, 1'b1);
      push(8'h3C, 1'b1);
      idle(100);
      check(frames == 0, "R3 held while disabled", frames, 0);
      rd(2'd2, r); check(r[2] == 1'b0, "R3 bytes still queued", r, 32'h0);

      // R4/R9 send both, pushing during the start of transmission
      wr(2'd0, 32'h0000_0301);
      push(8'h81, 1'b1);
      rd(2'd2, r); check(r[0] == 1'b1, "R9 busy during character", r, 32'h1);
      idle(3 * 160 + 40);
      check(frames == 3, "R4 three characters sent", frames, 3);
      rd(2'd2, r); check(r == 32'h4, "R9 busy cleared at end", r, 32'h4);

      // R5 disable mid-character
      wr(2'd0, 32'h0000_0300);
      f0 = frames;
      push(8'h5A, 1'b1);
      push(8'hF0, 1'b0);
      wr(2'd0, 32'h0000_0301);
      idle(40);
      wr(2'd0, 32'h0000_0300);
      idle(300);
      check(frames == f0 + 1, "R5 in-flight character completed", frames, f0 + 1);
      rd(2'd2, r); check(r == 32'h0, "R5 no further start, byte left", r, 32'h0);

      // R8 flush, with a push in the same cycle
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0;
      push_valid = 1'b1; push_data = 8'h77;
      @(negedge clk);
      reg_we = 1'b0; push_valid = 1'b0;
      rd(2'd2, r); check(r == 32'h4, "R8 flushed incl same-cycle push", r, 32'h4);
      wr(2'd1, 32'h1);
      f0 = frames;
      wr(2'd0, 32'h0000_0301);
      idle(200);
      check(frames == f0, "R8 nothing left to send", frames, f0);

      // R11 send-permit gating
      wr(2'd0, 32'h0000_0201);
      push(8'hC3, 1'b1);
      idle(100);
      check(frames == f0, "R11 held while send permit clear", frames, f0);
      wr(2'd0, 32'h0000_0301);
      idle(200);
      check(frames == f0 + 1, "R11 sent after permit", frames, f0 + 1);

      // R6 flow control blocks, then releases
      f0 = frames;
      cts = 1'b0;
      wr(2'd0, 32'h0000_8301);
      push(8'h1E, 1'b1);
      idle(100);
      check(frames == f0, "R6 held while cts low", frames, f0);
      rd(2'd2, r); check(r[0] == 1'b0, "R6 not busy while blocked", r, 32'h0);
      cts = 1'b1;
      idle(200);
      check(frames == f0 + 1, "R6 sent after cts high", frames, f0 + 1);

      // R7 cts drop mid-character
      push(8'h69, 1'b1);
      idle(30);
      cts = 1'b0;
      idle(200);
      check(frames == f0 + 2, "R7 character not cut", frames, f0 + 2);

      // R6 cts ignored with flow control off
      wr(2'd0, 32'h0000_0301);
      push(8'h42, 1'b1);
      idle(200);
      check(frames == f0 + 3, "R6 cts ignored when flow off", frames, f0 + 3);

      // R10 overflow, R9 continuous busy across back-to-back
      wr(2'd0, 32'h0000_0300);
      for (int i = 0; i < 17; i++) push(8'(i * 13 + 1), i < 16);
      rd(2'd2, r); check(r == 32'hA, "R10 full and overflow", r, 32'hA);
      f0 = frames;
      wr(2'd0, 32'h0000_0301);
      reg_addr = 2'd2;
      gaps = 0;
      for (int i = 0; i < 16 * 160 - 20; i++) begin
         @(negedge clk);
         #1 if (reg_rdata[0] !== 1'b1) gaps++;
      end
      check(gaps == 0, "R9 busy without gap", gaps, 0);
      idle(100);
      check(frames == f0 + 16, "R10 sixteen characters kept", frames, f0 + 16);
      rd(2'd2, r); check(r == 32'h6, "R10 overflow sticky", r, 32'h6);
      wr(2'd2, 32'h2);
      rd(2'd2, r); check(r == 32'h4, "R10 overflow cleared", r, 32'h4);
      check(expq.size() == 0, "R4 scoreboard drained", expq.size(), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule